// File: doc/BRIEF.md
# Character Dot Class Composer

This block sits in the dot pipeline of an on-screen text overlay. For every display dot it takes the font dot of the current character together with its eight surrounding font dots, the character code, two per-character attribute bits, two area flags and a handful of global control bits. From these it decides which of four classes the dot belongs to: transparent (the incoming video shows through), character, frame (an outline around the glyph), or background (a solid box). A later stage turns the class into an output level. The block also drives a highlight flag for characters that carry the mark attribute while highlighting is selected.

A small field-rate timer counts vertical sync ticks and produces the on/off phase used by flashing characters. The half period is picked from four field counts by a 50 Hz/60 Hz selector and a slow/fast selector. Optional corner rounding smooths diagonal steps of enlarged characters. The reverse attribute swaps glyph and background inside the cell. An edge-mode bit extends the outline to reversed cells.

Top module: `osd_pix_composer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pix_class` is 0 (transparent) and `hilite` is 0. The flash phase leaves reset in its visible half.
- R2: A dot whose `code` is 8'hFF is transparent (class 0) whatever the attributes, area flags or blanking mode.
- R3: Class encoding is 0 transparent, 1 character, 2 frame, 3 background. Inside a cell with `attr_inv`=0, a set dot is class 1. A clear dot depends on `blank_mode`. With 00 it is 0. With 01 or 11 it is 3. With 10 it is 2 if one of its four side neighbours is set, and 0 otherwise.
- R4: Outside a cell (`in_cell`=0), a dot is class 3 when `blank_mode`=11 and `in_window`=1, and class 0 in every other case.
- R5: With `attr_inv`=1, glyph and neighbour dots are inverted first. An inverted-set dot is class 1. Any other dot is class 3, except as set out in R6.
- R6: With `attr_inv`=1 and `blank_mode`=10, an inverted-clear dot that has an inverted-set side neighbour is class 2 when `edge_on_inv`=1, and class 3 when `edge_on_inv`=0.
- R7: `nbr` bits are 0 N, 1 NE, 2 E, 3 SE, 4 S, 5 SW, 6 W, 7 NW. With `round_en`=1 and `char_size` 01 (double) or 10 (triple), a clear dot is filled when both dots on one of its corners are set and the diagonal dot between them is clear. With `char_size` 00 or 11 (normal), no fill happens.
- R8: Code 8'hFE is an empty glyph. Its dot and neighbour inputs are treated as clear.
- R9: `hilite` is 1 one cycle after a dot with `in_cell`=1, `attr_mark`=1, `at2_is_flash`=0 and a code other than 8'hFF. Otherwise it is 0, and highlight leaves the class unchanged.
- R10: The flash phase toggles after a fixed number of `field_tick` pulses. With `rate50`=0 the count is 15 (`flash_slow`=0) or 30 (`flash_slow`=1). With `rate50`=1 it is 12 or 25. The phase changes on no other cycle.
- R11: In the hidden flash half, every dot of a cell with `attr_mark`=1 and `at2_is_flash`=1 is class 3 when `blank_mode` is 01 or 11, and class 0 otherwise.
- R12: `pix_class` and `hilite` are registered. They reflect the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| field_tick | input | 1 | One-cycle pulse per vertical sync |
| rate50 | input | 1 | 1 selects 50 Hz field counts, 0 selects 60 Hz |
| flash_slow | input | 1 | 1 selects the long flash period |
| at2_is_flash | input | 1 | 1 makes the mark attribute flash, 0 makes it highlight |
| blank_mode | input | 2 | 00 none, 01 cell box, 10 outline, 11 full window |
| edge_on_inv | input | 1 | Apply the outline to reversed cells too |
| round_en | input | 1 | Enable corner rounding |
| char_size | input | 2 | 00 normal, 01 double, 10 triple, 11 normal |
| in_cell | input | 1 | Dot lies inside a character cell |
| in_window | input | 1 | Dot lies inside the text window |
| code | input | 8 | Character code of the cell |
| attr_inv | input | 1 | Reverse attribute |
| attr_mark | input | 1 | Highlight/flash attribute |
| dot | input | 1 | Font dot at this position |
| nbr | input | 8 | Surrounding font dots, order given in R7 |
| pix_class | output | 2 | Dot class, encoding in R3 |
| hilite | output | 1 | Highlight flag |

## Verification
Both `pix_class` and `hilite` are due one clock edge after their inputs are presented. The flash phase changes at the edge that samples the last counted tick, so it first shows in the class one edge later. The bench drives inputs at the falling edge. Right after each rising edge it computes the expected class from its own phase model, which it advances only after that computation. It then compares at the next falling edge, so every comparison lines up with the single register stage and the phase lag.

// File: rtl/osd_pix_pkg.sv
package osd_pix_pkg;

    typedef enum logic [1:0] {
        PX_TRANSP = 2'd0,
        PX_CHAR   = 2'd1,
        PX_FRAME  = 2'd2,
        PX_BACK   = 2'd3
    } pix_class_e;

    typedef enum logic [1:0] {
        BLK_NONE    = 2'd0,
        BLK_CELL    = 2'd1,
        BLK_OUTLINE = 2'd2,
        BLK_FULL    = 2'd3
    } blank_e;

    localparam logic [7:0] CODE_TRANSP = 8'hFF;
    localparam logic [7:0] CODE_SPACE  = 8'hFE;

    // neighbour index positions
    localparam int NB_N  = 0;
    localparam int NB_NE = 1;
    localparam int NB_E  = 2;
    localparam int NB_SE = 3;
    localparam int NB_S  = 4;
    localparam int NB_SW = 5;
    localparam int NB_W  = 6;
    localparam int NB_NW = 7;

    typedef struct packed {
        logic on;
        logic border;
    } shape_t;

    function automatic logic side_any(input logic [7:0] n);
        return n[NB_N] | n[NB_E] | n[NB_S] | n[NB_W];
    endfunction

    function automatic logic corner_fill(input logic d, input logic [7:0] n);
        logic c;
        c = (n[NB_N] & n[NB_E] & ~n[NB_NE]) |
            (n[NB_E] & n[NB_S] & ~n[NB_SE]) |
            (n[NB_S] & n[NB_W] & ~n[NB_SW]) |
            (n[NB_W] & n[NB_N] & ~n[NB_NW]);
        return ~d & c;
    endfunction

    function automatic logic is_enlarged(input logic [1:0] sz);
        return (sz == 2'b01) || (sz == 2'b10);
    endfunction

endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer #(
    parameter int HALF_FAST60 = 15,
    parameter int HALF_SLOW60 = 30,
    parameter int HALF_FAST50 = 12,
    parameter int HALF_SLOW50 = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic field_tick,
    input  logic rate50,
    input  logic flash_slow,
    output logic hide_phase
);
    localparam int MAX_A  = (HALF_FAST60 > HALF_SLOW60) ? HALF_FAST60 : HALF_SLOW60;
    localparam int MAX_B  = (HALF_FAST50 > HALF_SLOW50) ? HALF_FAST50 : HALF_SLOW50;
    localparam int MAX_H  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_H + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        unique case ({rate50, flash_slow})
            2'b00:   limit = CW'(HALF_FAST60);
            2'b01:   limit = CW'(HALF_SLOW60);
            2'b10:   limit = CW'(HALF_FAST50);
            default: limit = CW'(HALF_SLOW50);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            hide_phase <= 1'b0;
        end else if (field_tick) begin
            if (cnt + 1'b1 >= limit) begin
                cnt        <= '0;
                hide_phase <= ~hide_phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osd_glyph_shaper.sv
module osd_glyph_shaper
    import osd_pix_pkg::*;
(
    input  logic       dot,
    input  logic [7:0] nbr,
    input  logic [7:0] code,
    input  logic       attr_inv,
    input  logic       round_en,
    input  logic [1:0] char_size,
    output shape_t     shape
);
    logic       empty;
    logic       d;
    logic [7:0] n;
    logic       rd;
    logic       eff;
    logic [7:0] en;

    always_comb begin
        empty = (code == CODE_SPACE);
        d     = empty ? 1'b0 : dot;
        n     = empty ? 8'h00 : nbr;
        rd    = d | (round_en & is_enlarged(char_size) & corner_fill(d, n));
        eff   = attr_inv ? ~rd : rd;
        en    = attr_inv ? ~n : n;
        shape.on     = eff;
        shape.border = ~eff & side_any(en);
    end
endmodule

// File: rtl/osd_class_mux.sv
module osd_class_mux
    import osd_pix_pkg::*;
(
    input  shape_t     shape,
    input  logic       in_cell,
    input  logic       in_window,
    input  logic [7:0] code,
    input  logic       attr_inv,
    input  logic       hidden,
    input  logic [1:0] blank_mode,
    input  logic       edge_on_inv,
    output pix_class_e cls
);
    blank_e     bm;
    pix_class_e plain_bg;

    always_comb begin
        bm       = blank_e'(blank_mode);
        plain_bg = (bm == BLK_CELL || bm == BLK_FULL) ? PX_BACK : PX_TRANSP;
        if (code == CODE_TRANSP)
            cls = PX_TRANSP;
        else if (!in_cell)
            cls = (bm == BLK_FULL && in_window) ? PX_BACK : PX_TRANSP;
        else if (hidden)
            cls = plain_bg;
        else if (shape.on)
            cls = PX_CHAR;
        else if (shape.border && bm == BLK_OUTLINE && (!attr_inv || edge_on_inv))
            cls = PX_FRAME;
        else if (attr_inv)
            cls = PX_BACK;
        else
            cls = plain_bg;
    end
endmodule

// File: rtl/osd_pix_composer.sv
module osd_pix_composer
    import osd_pix_pkg::*;
#(
    parameter int HALF_FAST60 = 15,
    parameter int HALF_SLOW60 = 30,
    parameter int HALF_FAST50 = 12,
    parameter int HALF_SLOW50 = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       field_tick,
    input  logic       rate50,
    input  logic       flash_slow,
    input  logic       at2_is_flash,
    input  logic [1:0] blank_mode,
    input  logic       edge_on_inv,
    input  logic       round_en,
    input  logic [1:0] char_size,
    input  logic       in_cell,
    input  logic       in_window,
    input  logic [7:0] code,
    input  logic       attr_inv,
    input  logic       attr_mark,
    input  logic       dot,
    input  logic [7:0] nbr,
    output logic [1:0] pix_class,
    output logic       hilite
);
    logic       hide_phase;
    shape_t     shape;
    pix_class_e cls_d;
    logic       hidden;
    logic       hilite_d;

    osd_flash_timer #(
        .HALF_FAST60 (HALF_FAST60),
        .HALF_SLOW60 (HALF_SLOW60),
        .HALF_FAST50 (HALF_FAST50),
        .HALF_SLOW50 (HALF_SLOW50)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .field_tick (field_tick),
        .rate50     (rate50),
        .flash_slow (flash_slow),
        .hide_phase (hide_phase)
    );

    osd_glyph_shaper u_shape (
        .dot       (dot),
        .nbr       (nbr),
        .code      (code),
        .attr_inv  (attr_inv),
        .round_en  (round_en),
        .char_size (char_size),
        .shape     (shape)
    );

    assign hidden   = hide_phase & attr_mark & at2_is_flash;
    assign hilite_d = in_cell & attr_mark & ~at2_is_flash & (code != CODE_TRANSP);

    osd_class_mux u_mux (
        .shape       (shape),
        .in_cell     (in_cell),
        .in_window   (in_window),
        .code        (code),
        .attr_inv    (attr_inv),
        .hidden      (hidden),
        .blank_mode  (blank_mode),
        .edge_on_inv (edge_on_inv),
        .cls         (cls_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_class <= PX_TRANSP;
            hilite    <= 1'b0;
        end else begin
            pix_class <= cls_d;
            hilite    <= hilite_d;
        end
    end
endmodule

// File: rtl/osd_pix_composer_chk.sv
module osd_pix_composer_chk
    import osd_pix_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       field_tick,
    input logic       at2_is_flash,
    input logic [1:0] blank_mode,
    input logic       in_cell,
    input logic       in_window,
    input logic [7:0] code,
    input logic       attr_mark,
    input logic       hide_phase,
    input logic [1:0] pix_class,
    input logic       hilite
);
    assert_transp_code_R2: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_TRANSP) |=> (pix_class == PX_TRANSP));

    assert_outside_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!in_cell && !in_window) |=> (pix_class == PX_TRANSP));

    assert_frame_only_outline_R3: assert property (@(posedge clk) disable iff (rst)
        (blank_mode != 2'b10) |=> (pix_class != PX_FRAME));

    assert_hilite_set_R9: assert property (@(posedge clk) disable iff (rst)
        (in_cell && attr_mark && !at2_is_flash && code != CODE_TRANSP) |=> hilite);

    assert_hilite_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_cell && attr_mark && !at2_is_flash && code != CODE_TRANSP) |=> !hilite);

    assert_phase_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
        !field_tick |=> $stable(hide_phase));
endmodule

bind osd_pix_composer osd_pix_composer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .field_tick   (field_tick),
    .at2_is_flash (at2_is_flash),
    .blank_mode   (blank_mode),
    .in_cell      (in_cell),
    .in_window    (in_window),
    .code         (code),
    .attr_mark    (attr_mark),
    .hide_phase   (hide_phase),
    .pix_class    (pix_class),
    .hilite       (hilite)
);

// File: tb/osd_pix_composer_bench.sv
`timescale 1ns/1ps
module osd_pix_composer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       field_tick = 0, rate50 = 0, flash_slow = 0, at2_is_flash = 0;
    logic [1:0] blank_mode = 0;
    logic       edge_on_inv = 0, round_en = 0;
    logic [1:0] char_size = 0;
    logic       in_cell = 0, in_window = 0;
    logic [7:0] code = 0;
    logic       attr_inv = 0, attr_mark = 0, dot = 0;
    logic [7:0] nbr = 0;
    logic [1:0] pix_class;
    logic       hilite;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench phase model
    int m_cnt = 0;
    bit m_hide = 0;

    always #2.5 clk = ~clk;

    osd_pix_composer u_osd_pix_composer (
        .clk(clk), .rst(rst), .field_tick(field_tick), .rate50(rate50),
        .flash_slow(flash_slow), .at2_is_flash(at2_is_flash),
        .blank_mode(blank_mode), .edge_on_inv(edge_on_inv), .round_en(round_en),
        .char_size(char_size), .in_cell(in_cell), .in_window(in_window),
        .code(code), .attr_inv(attr_inv), .attr_mark(attr_mark), .dot(dot),
        .nbr(nbr), .pix_class(pix_class), .hilite(hilite)
    );

    function automatic int half_len();
        if (!rate50) return flash_slow ? 30 : 15;
        return flash_slow ? 25 : 12;
    endfunction

    function automatic logic [1:0] ref_class();
        logic       d, rd, eff, bord, fill;
        logic [7:0] n, en;
        logic [1:0] plain;
        plain = (blank_mode == 2'b01 || blank_mode == 2'b11) ? 2'd3 : 2'd0;
        if (code == 8'hFF) return 2'd0;
        if (!in_cell) return (blank_mode == 2'b11 && in_window) ? 2'd3 : 2'd0;
        if (m_hide && attr_mark && at2_is_flash) return plain;
        d = (code == 8'hFE) ? 1'b0 : dot;
        n = (code == 8'hFE) ? 8'h00 : nbr;
        fill = !d && ((n[0] && n[2] && !n[1]) || (n[2] && n[4] && !n[3]) ||
                      (n[4] && n[6] && !n[5]) || (n[6] && n[0] && !n[7]));
        rd = d || (round_en && (char_size == 2'b01 || char_size == 2'b10) && fill);
        eff = attr_inv ? !rd : rd;
        en = attr_inv ? ~n : n;
        bord = !eff && (en[0] || en[2] || en[4] || en[6]);
        if (eff) return 2'd1;
        if (bord && blank_mode == 2'b10 && (!attr_inv || edge_on_inv)) return 2'd2;
        if (attr_inv) return 2'd3;
        return plain;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one clock: expected taken at the rising edge, compared at the falling edge
    task automatic step(input string req);
        logic [1:0] ec;
        logic       eh;
        @(posedge clk);
        ec = ref_class();
        eh = in_cell && attr_mark && !at2_is_flash && code != 8'hFF;
        if (field_tick) begin
            if (m_cnt + 1 >= half_len()) begin
                m_cnt = 0;
                m_hide = !m_hide;
            end else m_cnt++;
        end
        @(negedge clk);
        chk({req, " class"}, pix_class, ec);
        chk({req, " hilite"}, hilite, eh);
    endtask

    task automatic plain_cell();
        field_tick = 0; in_cell = 1; in_window = 1; code = 8'h41;
        attr_inv = 0; attr_mark = 0; dot = 0; nbr = 0;
        blank_mode = 0; edge_on_inv = 0; round_en = 0; char_size = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        code = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset class", pix_class, 0);
        chk("R1 reset hilite", hilite, 0);
        rst = 0;
        // R1/R12: first cycle after reset, transparent input gives transparent
        step("R1");

        // R3 normal cell under each blanking mode
        plain_cell(); dot = 1; step("R3"); chk("R3 glyph char", pix_class, 1);
        dot = 0; blank_mode = 2'b00; step("R3"); chk("R3 none", pix_class, 0);
        blank_mode = 2'b01; step("R3"); chk("R3 cell box", pix_class, 3);
        blank_mode = 2'b10; nbr = 8'h04; step("R3"); chk("R3 outline", pix_class, 2);
        nbr = 8'h02; step("R3"); chk("R3 outline diag only", pix_class, 0);
        blank_mode = 2'b11; step("R3"); chk("R3 full", pix_class, 3);
        // R12: output follows the previous cycle's input only
        dot = 1; step("R12"); chk("R12 latency", pix_class, 1);

        // R2 transparent code
        code = 8'hFF; blank_mode = 2'b11; attr_inv = 1; step("R2");
        chk("R2 transparent", pix_class, 0);

        // R4 outside cell
        plain_cell(); in_cell = 0; blank_mode = 2'b11; step("R4");
        chk("R4 window", pix_class, 3);
        in_window = 0; step("R4"); chk("R4 outside", pix_class, 0);
        in_window = 1; blank_mode = 2'b01; step("R4"); chk("R4 cell mode", pix_class, 0);

        // R5 reverse
        plain_cell(); attr_inv = 1; dot = 0; step("R5"); chk("R5 bg->char", pix_class, 1);
        dot = 1; nbr = 8'hFF; step("R5"); chk("R5 glyph->back", pix_class, 3);

        // R6 edge on reversed cells
        plain_cell(); attr_inv = 1; dot = 1; nbr = 8'h00; blank_mode = 2'b10;
        edge_on_inv = 1; step("R6"); chk("R6 edge on", pix_class, 2);
        edge_on_inv = 0; step("R6"); chk("R6 edge off", pix_class, 3);

        // R7 rounding
        plain_cell(); round_en = 1; nbr = 8'h05; char_size = 2'b01;
        step("R7"); chk("R7 double fill", pix_class, 1);
        char_size = 2'b10; step("R7"); chk("R7 triple fill", pix_class, 1);
        char_size = 2'b00; step("R7"); chk("R7 normal none", pix_class, 0);
        char_size = 2'b11; step("R7"); chk("R7 normal alt none", pix_class, 0);
        char_size = 2'b01; nbr = 8'h07; step("R7"); chk("R7 diag set", pix_class, 0);

        // R8 space code
        plain_cell(); code = 8'hFE; dot = 1; nbr = 8'hFF; blank_mode = 2'b10;
        step("R8"); chk("R8 empty glyph", pix_class, 0);

        // R9 highlight
        plain_cell(); attr_mark = 1; dot = 1; step("R9"); chk("R9 hilite", hilite, 1);
        chk("R9 class kept", pix_class, 1);
        at2_is_flash = 1; step("R9"); chk("R9 flash no hilite", hilite, 0);

        // R10/R11 flash timing, 60 Hz fast
        plain_cell(); attr_mark = 1; at2_is_flash = 1; dot = 1; rate50 = 0; flash_slow = 0;
        field_tick = 1;
        for (int i = 0; i < 15; i++) step("R10");
        field_tick = 0; step("R10"); chk("R10 hidden after 15", pix_class, 0);
        blank_mode = 2'b01; step("R11"); chk("R11 hidden box", pix_class, 3);
        field_tick = 1;
        for (int i = 0; i < 14; i++) step("R10");
        field_tick = 0; step("R10"); chk("R10 still hidden at 14", pix_class, 3);
        field_tick = 1; step("R10"); field_tick = 0; step("R10");
        chk("R10 visible again", pix_class, 1);
        // 50 Hz slow
        rate50 = 1; flash_slow = 1; field_tick = 1;
        for (int i = 0; i < 25; i++) step("R10");
        field_tick = 0; step("R10"); chk("R10 hidden after 25", pix_class, 3);

        // random segment
        for (int seg = 0; seg < 8; seg++) begin
            rate50 = 1'($urandom); flash_slow = 1'($urandom); at2_is_flash = 1'($urandom);
            for (int i = 0; i < 500; i++) begin
                field_tick = ($urandom % 8) == 0;
                blank_mode = 2'($urandom); edge_on_inv = 1'($urandom);
                round_en = 1'($urandom); char_size = 2'($urandom);
                in_cell = ($urandom % 8) != 0; in_window = 1'($urandom);
                case ($urandom % 8)
                    0: code = 8'hFF;
                    1: code = 8'hFE;
                    default: code = 8'($urandom % 254);
                endcase
                attr_inv = 1'($urandom); attr_mark = 1'($urandom);
                dot = 1'($urandom); nbr = 8'($urandom);
                step("R3/R5/R7/R10 random");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule